// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits between two byte sources, a keyboard channel and an auxiliary (pointing device) channel, and the single host-visible data port they share. Each source raises a level while it holds a byte for the host. The arbiter registers those two levels into a pending mask. From that mask it builds the output-buffer-full flags in the status byte and in the output-port image, the two interrupt request levels, and the selector that steers the shared data-port read.

Keyboard data always wins. The auxiliary source is reported, interrupts the host and is read only when it is the sole pending source. The mode byte gates each interrupt. A separate keyboard-off bit in the mode byte also masks the keyboard interrupt. A host read of the data port returns the selected source's byte and sends a pop strobe to that source only.

Top module: `kbc_obf_arb`

## Requirements
- R1: Each bit of the pending mask takes its source's level input at the rising clock edge. Bit 0 is the keyboard and bit 1 is the auxiliary source. All flags, IRQs and the read selection follow the registered mask, one clock after an input change.
- R2: When either pending bit is set, status bit 0 and `outport_obf_o[0]` (output-port bit 4) are 1. When no bit is set, both are 0.
- R3: Status bit 5 and `outport_obf_o[1]` (output-port bit 5) are 1 only when the mask is auxiliary-only (binary 10). They are 0 when both sources are pending.
- R4: `aux_irq_o` is 1 exactly when the mask is auxiliary-only and mode bit 1 is set.
- R5: `kbd_irq_o` is 1 exactly when keyboard data is pending, mode bit 0 is set and mode bit 4 (keyboard off) is clear. This holds whether or not auxiliary data is also pending.
- R6: `rd_data_o` carries `aux_data_i` only when the mask is auxiliary-only. Otherwise it carries `kbd_data_i`.
- R7: While `rd_i` is high, exactly one pop strobe is high and it goes to the source chosen by R6. While `rd_i` is low, neither pop strobe is high.
- R8: During and right after reset the mask is empty, the status byte reads 0x18 (bit 3 last-write-was-command and bit 4 unlocked set), and both IRQs are low.
- R9: Mode bits 2, 3, 5, 6 and 7 have no effect on the flags or the IRQs. A change of mode bits 0, 1 or 4 shows on the IRQs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kbd_pend_i | input | 1 | Keyboard source holds a byte (level) |
| aux_pend_i | input | 1 | Auxiliary source holds a byte (level) |
| mode_i | input | 8 | Controller mode byte |
| rd_i | input | 1 | Host data-port read strobe |
| kbd_data_i | input | 8 | Keyboard source head byte |
| aux_data_i | input | 8 | Auxiliary source head byte |
| status_o | output | 8 | Status byte |
| outport_obf_o | output | 2 | Output-port bits 4 (any full) and 5 (aux full) |
| kbd_irq_o | output | 1 | Keyboard interrupt level |
| aux_irq_o | output | 1 | Auxiliary interrupt level |
| rd_data_o | output | 8 | Data-port read value |
| kbd_pop_o | output | 1 | Pop strobe to keyboard source |
| aux_pop_o | output | 1 | Pop strobe to auxiliary source |

## Verification
The only state is the two-bit pending mask. A wrong mask bit shows on the clock edge after the input change, in several places at once: status bits 0 and 5, the output-port flags, the read selector, and whichever pop strobe fires. The IRQ and read paths are combinational from that mask and the mode byte, so a wrong gating term shows within the same cycle as the mode change. Every mask value is therefore held for at least one cycle while each of the gating mode bits is swept, and reads are issued at each mask value.

// File: rtl/kbc_arb_pkg.sv
package kbc_arb_pkg;
  localparam int unsigned ST_W      = 8;
  localparam int unsigned ST_OBF    = 0;
  localparam int unsigned ST_CMD    = 3;
  localparam int unsigned ST_UNLK   = 4;
  localparam int unsigned ST_AUXOBF = 5;
  localparam int unsigned N_SRC     = 2;

  typedef enum logic {SRC_KBD = 1'b0, SRC_AUX = 1'b1} src_e;

  typedef struct packed {
    logic aux;
    logic kbd;
  } pend_t;
endpackage

// File: rtl/kbc_pend_reg.sv
module kbc_pend_reg
  import kbc_arb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  kbd_lvl_i,
  input  logic  aux_lvl_i,
  output pend_t pend_o,
  output logic  any_o,
  output logic  aux_only_o,
  output src_e  sel_o
);
  logic [N_SRC-1:0] lvl;
  logic [N_SRC-1:0] mask_q;

  assign lvl = {aux_lvl_i, kbd_lvl_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[g] <= 1'b0;
      else         mask_q[g] <= lvl[g];
    end
  end

  assign pend_o     = pend_t'(mask_q);
  assign any_o      = |mask_q;
  // keyboard has strict priority
  assign aux_only_o = pend_o.aux & ~pend_o.kbd;
  assign sel_o      = aux_only_o ? SRC_AUX : SRC_KBD;
endmodule

// File: rtl/kbc_flag_gen.sv
module kbc_flag_gen
  import kbc_arb_pkg::*;
#(
  parameter int unsigned MODE_W      = 8,
  parameter int unsigned KBD_INT_BIT = 0,
  parameter int unsigned AUX_INT_BIT = 1,
  parameter int unsigned KBD_OFF_BIT = 4
) (
  input  pend_t             pend_i,
  input  logic              any_i,
  input  logic              aux_only_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [ST_W-1:0]   status_o,
  output logic [1:0]        outport_obf_o,
  output logic              kbd_irq_o,
  output logic              aux_irq_o
);
  always_comb begin
    status_o            = '0;
    status_o[ST_CMD]    = 1'b1;
    status_o[ST_UNLK]   = 1'b1;
    status_o[ST_OBF]    = any_i;
    status_o[ST_AUXOBF] = aux_only_i;
  end

  assign outport_obf_o = {aux_only_i, any_i};
  assign aux_irq_o     = aux_only_i & mode_i[AUX_INT_BIT];
  assign kbd_irq_o     = pend_i.kbd & mode_i[KBD_INT_BIT] & ~mode_i[KBD_OFF_BIT];
endmodule

// File: rtl/kbc_rd_port.sv
module kbc_rd_port
  import kbc_arb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  src_e              sel_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] kbd_data_i,
  input  logic [DATA_W-1:0] aux_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              kbd_pop_o,
  output logic              aux_pop_o
);
  assign rd_data_o = (sel_i == SRC_AUX) ? aux_data_i : kbd_data_i;
  assign kbd_pop_o = rd_i & (sel_i == SRC_KBD);
  assign aux_pop_o = rd_i & (sel_i == SRC_AUX);
endmodule

// File: rtl/kbc_obf_arb.sv
module kbc_obf_arb
  import kbc_arb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MODE_W      = 8,
  parameter int unsigned KBD_INT_BIT = 0,
  parameter int unsigned AUX_INT_BIT = 1,
  parameter int unsigned KBD_OFF_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kbd_pend_i,
  input  logic              aux_pend_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] kbd_data_i,
  input  logic [DATA_W-1:0] aux_data_i,
  output logic [ST_W-1:0]   status_o,
  output logic [1:0]        outport_obf_o,
  output logic              kbd_irq_o,
  output logic              aux_irq_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              kbd_pop_o,
  output logic              aux_pop_o
);
  pend_t pend;
  logic  any_pend;
  logic  aux_only;
  src_e  sel;

  kbc_pend_reg u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kbd_lvl_i  (kbd_pend_i),
    .aux_lvl_i  (aux_pend_i),
    .pend_o     (pend),
    .any_o      (any_pend),
    .aux_only_o (aux_only),
    .sel_o      (sel)
  );

  kbc_flag_gen #(
    .MODE_W      (MODE_W),
    .KBD_INT_BIT (KBD_INT_BIT),
    .AUX_INT_BIT (AUX_INT_BIT),
    .KBD_OFF_BIT (KBD_OFF_BIT)
  ) u_flags (
    .pend_i        (pend),
    .any_i         (any_pend),
    .aux_only_i    (aux_only),
    .mode_i        (mode_i),
    .status_o      (status_o),
    .outport_obf_o (outport_obf_o),
    .kbd_irq_o     (kbd_irq_o),
    .aux_irq_o     (aux_irq_o)
  );

  kbc_rd_port #(.DATA_W(DATA_W)) u_rd (
    .sel_i      (sel),
    .rd_i       (rd_i),
    .kbd_data_i (kbd_data_i),
    .aux_data_i (aux_data_i),
    .rd_data_o  (rd_data_o),
    .kbd_pop_o  (kbd_pop_o),
    .aux_pop_o  (aux_pop_o)
  );
endmodule

// File: rtl/kbc_obf_arb_chk.sv
module kbc_obf_arb_chk #(
  parameter int unsigned MODE_W      = 8,
  parameter int unsigned KBD_INT_BIT = 0,
  parameter int unsigned AUX_INT_BIT = 1,
  parameter int unsigned KBD_OFF_BIT = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              kbd_pend_i,
  input logic              aux_pend_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              rd_i,
  input logic [7:0]        status_o,
  input logic [1:0]        outport_obf_o,
  input logic              kbd_irq_o,
  input logic              aux_irq_o,
  input logic              kbd_pop_o,
  input logic              aux_pop_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_obf_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> status_o[0] == ($past(kbd_pend_i) | $past(aux_pend_i)));

  a_r2_obf_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == outport_obf_o[0]);

  a_r3_aux_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> status_o[5] == ($past(aux_pend_i) & ~$past(kbd_pend_i)));

  a_r4_aux_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_irq_o |-> (outport_obf_o[1] && mode_i[AUX_INT_BIT]));

  a_r5_kbd_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_irq_o |-> (status_o[0] && !status_o[5] && mode_i[KBD_INT_BIT] && !mode_i[KBD_OFF_BIT]));

  a_r7_one_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({kbd_pop_o, aux_pop_o}) == (rd_i ? 1 : 0));

  a_r7_pop_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_pop_o |-> status_o[5]);
endmodule

bind kbc_obf_arb kbc_obf_arb_chk #(
  .MODE_W      (MODE_W),
  .KBD_INT_BIT (KBD_INT_BIT),
  .AUX_INT_BIT (AUX_INT_BIT),
  .KBD_OFF_BIT (KBD_OFF_BIT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .kbd_pend_i    (kbd_pend_i),
  .aux_pend_i    (aux_pend_i),
  .mode_i        (mode_i),
  .rd_i          (rd_i),
  .status_o      (status_o),
  .outport_obf_o (outport_obf_o),
  .kbd_irq_o     (kbd_irq_o),
  .aux_irq_o     (aux_irq_o),
  .kbd_pop_o     (kbd_pop_o),
  .aux_pop_o     (aux_pop_o)
);

// File: tb/sim_kbc_obf_arb.sv
module sim_kbc_obf_arb;
  localparam time CLK_T = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       kbd_pend_i = 1'b0;
  logic       aux_pend_i = 1'b0;
  logic [7:0] mode_i = 8'h03;
  logic       rd_i = 1'b0;
  logic [7:0] kbd_data_i = 8'h1c;
  logic [7:0] aux_data_i = 8'hb7;
  logic [7:0] status_o;
  logic [1:0] outport_obf_o;
  logic       kbd_irq_o, aux_irq_o;
  logic [7:0] rd_data_o;
  logic       kbd_pop_o, aux_pop_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk_i = ~clk_i;

  kbc_obf_arb u0 (.*);

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic set_pend(logic k, logic a);
    @(negedge clk_i);
    kbd_pend_i = k;
    aux_pend_i = a;
    @(negedge clk_i);
  endtask

  function automatic logic [7:0] exp_status(logic k, logic a);
    return {2'b00, a & ~k, 2'b11, 2'b00, k | a};
  endfunction

  task automatic t_reset();
    check("R8 status", status_o, 8'h18);
    check("R8 irqs", {6'd0, kbd_irq_o, aux_irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 status after release", status_o, 8'h18);
  endtask

  task automatic t_patterns();
    for (int p = 0; p < 4; p++) begin
      logic k, a;
      k = p[0];
      a = p[1];
      mode_i = 8'h03;
      // input seen only after one clock
      @(negedge clk_i);
      kbd_pend_i = k;
      aux_pend_i = a;
      #1;
      if (p != 0) check("R1 no early update", status_o, exp_status(1'b0, 1'b0));
      @(negedge clk_i);
      check("R1 R2 R3 status", status_o, exp_status(k, a));
      check("R2 R3 outport", {6'd0, outport_obf_o}, {6'd0, a & ~k, k | a});
      check("R4 aux irq", {7'd0, aux_irq_o}, {7'd0, a & ~k});
      check("R5 kbd irq", {7'd0, kbd_irq_o}, {7'd0, k});
      check("R6 read data", rd_data_o, (a & ~k) ? aux_data_i : kbd_data_i);
      set_pend(1'b0, 1'b0);
    end
  endtask

  task automatic t_irq_mask();
    set_pend(1'b1, 1'b1);
    mode_i = 8'h13; #1;
    check("R5 kbd off masks irq", {7'd0, kbd_irq_o}, 8'h00);
    mode_i = 8'h02; #1;
    check("R5 int bit clear", {7'd0, kbd_irq_o}, 8'h00);
    mode_i = 8'h01; #1;
    check("R9 same-cycle irq", {7'd0, kbd_irq_o}, 8'h01);
    set_pend(1'b0, 1'b1);
    mode_i = 8'h01; #1;
    check("R4 aux int clear", {7'd0, aux_irq_o}, 8'h00);
    mode_i = 8'h12; #1;
    check("R4 kbd off ignored for aux", {7'd0, aux_irq_o}, 8'h01);
    set_pend(1'b0, 1'b0);
  endtask

  task automatic t_ignored_bits();
    set_pend(1'b1, 1'b0);
    mode_i = 8'hed; #1;
    check("R9 kbd irq", {7'd0, kbd_irq_o}, 8'h01);
    check("R9 status", status_o, exp_status(1'b1, 1'b0));
    set_pend(1'b0, 1'b1);
    mode_i = 8'hee; #1;
    check("R9 aux irq", {6'd0, kbd_irq_o, aux_irq_o}, 8'h01);
    check("R9 status aux", status_o, exp_status(1'b0, 1'b1));
    set_pend(1'b0, 1'b0);
    mode_i = 8'h03;
  endtask

  task automatic t_reads();
    for (int p = 0; p < 4; p++) begin
      set_pend(p[0], p[1]);
      kbd_data_i = 8'h40 + 8'(p);
      aux_data_i = 8'h90 + 8'(p);
      check("R7 no pop idle", {6'd0, kbd_pop_o, aux_pop_o}, 8'h00);
      rd_i = 1'b1; #1;
      check("R6 data", rd_data_o, (p == 2) ? aux_data_i : kbd_data_i);
      check("R7 pop", {6'd0, kbd_pop_o, aux_pop_o}, (p == 2) ? 8'h01 : 8'h02);
      @(negedge clk_i);
      rd_i = 1'b0; #1;
      check("R7 pop ends", {6'd0, kbd_pop_o, aux_pop_o}, 8'h00);
    end
    set_pend(1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_patterns();
    t_irq_mask();
    t_ignored_bits();
    t_reads();
    finish_run();
  end

  initial begin
    #(CLK_T * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule